// File: doc/BRIEF.md
# MDIO Management Frame Master

This block produces register-access frames on a two-wire PHY management interface. A host presents one command: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then serialises the whole frame on a clock output and a data line that has a separate output-enable and an input sample path. When the frame is over it returns the 16-bit value captured from the PHY together with a single-cycle completion pulse.

Bit timing is set by the parameter `PHASE_CLKS`, the number of system clocks in one clock phase. Every bit the master drives spans three phases: clock low, clock high, clock low. The default of 100 gives about one microsecond per phase at a 100 MHz system clock. The two transfer directions end differently. A read releases the data line and gives one full clock pulse as turnaround before it shifts in the PHY's data. A write drives the turnaround itself, then its data, and finishes by letting go of the line for one phase without toggling the clock.

Top module: `mdio_frame_master`

## Requirements
- R1: Each frame opens with 32 driven bits that all read as 1.
- R2: The two bits after the preamble are 0 then 1. The next two are the operation: 1,0 for a read and 0,1 for a write (cmd_write=1).
- R3: After the operation come the PHY address (5 bits) and then the register address (5 bits), each sent most significant bit first.
- R4: On every driven bit mdc goes low, high, low. mdio_o holds steady across both clock edges, and the master produces exactly 64 rising mdc edges per write and 63 per read. done rises 193*PHASE_CLKS+1 cycles after the accepting edge for a write and 173*PHASE_CLKS+1 cycles after it for a read.
- R5: After the register address of a read, mdio_oe falls and exactly one mdc pulse follows with the line released. mdio_oe then stays low for 35*PHASE_CLKS cycles until done.
- R6: A read shifts in 16 bits from mdio_i, MSB first, each taken in the last system clock of an mdc high phase. The value appears on rd_data in the cycle done is high.
- R7: After the register address of a write, the master drives 1 then 0, followed by the 16 data bits MSB first.
- R8: After the last write data bit, mdio_oe goes low with mdc low for PHASE_CLKS cycles with no mdc edge, and done follows.
- R9: A command is taken only when cmd_valid is high while busy is low. cmd_valid raised while busy has no effect on the frame in progress.
- R10: done is a one-cycle pulse given while busy is high, and busy is low in the cycle after done.
- R11: Out of reset and between frames, mdc is low, mdio_oe is low and busy is low.
- R12: Every mdc high phase lasts exactly PHASE_CLKS system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | High from acceptance through done |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read value, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The checker assumes that commands arrive only through the cmd_valid/busy handshake. It also assumes that the PHY changes mdio_i only while mdc is low, so the value at the end of a high phase is settled. The bench's PHY model updates mdio_i only after it sees mdc fall, and it idles the line at 1. The bench holds a conflicting command on cmd_valid for a whole frame to show that commands raised while busy are ignored. It sweeps every PHY and register address and a walking-one data pattern in both directions.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned PRE_BITS  = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned HDR_BITS  = PRE_BITS + 2 + 2 + ADDR_W + ADDR_W;
  localparam int unsigned FRAME_W   = HDR_BITS + 2 + DATA_W;

  localparam logic [1:0] SOF_PAT   = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_DRIVE  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TURN,
    ST_RECV,
    ST_REL,
    ST_DONE
  } mdio_state_e;

  // Bits are left-aligned: bit FRAME_W-1 goes out first.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    logic [FRAME_W-1:0] f;
    if (wr) f = {{PRE_BITS{1'b1}}, SOF_PAT, OP_WRITE, phy, regad, TA_DRIVE, wd};
    else    f = {{PRE_BITS{1'b1}}, SOF_PAT, OP_READ, phy, regad, {(2 + DATA_W){1'b0}}};
    return f;
  endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int unsigned PHASE_CLKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (PHASE_CLKS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(PHASE_CLKS);
      localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;
      logic          at_last;

      always_comb begin
        at_last = (cnt_q == LAST);
        cnt_en  = run || (cnt_q != '0);
        if (!run || at_last) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
      end

      assign tick = run && at_last;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  logic        tick,
  output mdio_state_e state,
  output logic [1:0]  phase,
  output logic        run,
  output logic        shift_tx,
  output logic        sample_rx
);

  localparam int unsigned SLOT_W = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] LAST_WR   = SLOT_W'(FRAME_W - 1);
  localparam logic [SLOT_W-1:0] LAST_RD   = SLOT_W'(HDR_BITS - 1);
  localparam logic [SLOT_W-1:0] LAST_RECV = SLOT_W'(DATA_W - 1);

  mdio_state_e       state_q, state_d;
  logic [1:0]        phase_q, phase_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              wr_q, wr_d;
  logic              ctl_en;
  logic [SLOT_W-1:0] last_send;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    slot_d    = slot_q;
    wr_d      = wr_q;
    last_send = wr_q ? LAST_WR : LAST_RD;
    ctl_en    = (state_q != ST_IDLE) || start;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SEND;
          phase_d = '0;
          slot_d  = '0;
          wr_d    = start_wr;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (phase_q == 2'd2) begin
            phase_d = '0;
            if (slot_q == last_send) begin
              slot_d  = '0;
              state_d = wr_q ? ST_REL : ST_TURN;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      ST_TURN: begin
        if (tick) begin
          if (phase_q == 2'd2) begin
            phase_d = '0;
            slot_d  = '0;
            state_d = ST_RECV;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (tick) begin
          if (phase_q == 2'd1) begin
            phase_d = '0;
            if (slot_q == LAST_RECV) state_d = ST_DONE;
            else                     slot_d  = slot_q + 1'b1;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      ST_REL: begin
        if (tick) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      slot_q  <= '0;
      wr_q    <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      wr_q    <= wr_d;
    end
  end

  assign state     = state_q;
  assign phase     = phase_q;
  assign run       = (state_q == ST_SEND) || (state_q == ST_TURN) ||
                     (state_q == ST_RECV) || (state_q == ST_REL);
  assign shift_tx  = (state_q == ST_SEND) && tick && (phase_q == 2'd2);
  assign sample_rx = (state_q == ST_RECV) && tick && (phase_q == 2'd0);

endmodule

// File: rtl/mdio_bit_shifter.sv
module mdio_bit_shifter
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic               shift_tx,
  input  logic               sample_rx,
  input  logic               rx_bit,
  output logic               tx_bit,
  output logic [DATA_W-1:0]  rx_data
);

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               tx_en, rx_en;

  always_comb begin
    tx_en = load || shift_tx;
    rx_en = load || sample_rx;
    if (load) tx_d = load_frame;
    else      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    if (load) rx_d = '0;
    else      rx_d = {rx_q[DATA_W-2:0], rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign tx_bit  = tx_q[FRAME_W-1];
  assign rx_data = rx_q;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int unsigned PHASE_CLKS = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  mdio_state_e        state;
  logic [1:0]         phase;
  logic               run, tick, shift_tx, sample_rx, accept, tx_bit;
  logic [FRAME_W-1:0] frame_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign accept    = cmd_valid && (state == ST_IDLE);
  assign frame_vec = build_frame(cmd_write, cmd_phy, cmd_reg, cmd_wdata);

  mdio_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  mdio_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (accept),
    .start_wr  (cmd_write),
    .tick      (tick),
    .state     (state),
    .phase     (phase),
    .run       (run),
    .shift_tx  (shift_tx),
    .sample_rx (sample_rx)
  );

  mdio_bit_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept),
    .load_frame (frame_vec),
    .shift_tx   (shift_tx),
    .sample_rx  (sample_rx),
    .rx_bit     (mdio_i),
    .tx_bit     (tx_bit),
    .rx_data    (rd_data)
  );

  always_comb begin
    busy    = (state != ST_IDLE);
    done    = (state == ST_DONE);
    mdio_oe = (state == ST_SEND);
    mdio_o  = mdio_oe && tx_bit;
    case (state)
      ST_SEND, ST_TURN: mdc = (phase == 2'd1);
      ST_RECV:          mdc = (phase == 2'd0);
      default:          mdc = 1'b0;
    endcase
  end

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int unsigned PHASE_CLKS = 100
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_write,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  logic       mdc_prev;
  logic [7:0] rises;
  logic       wr_lat;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_prev <= 1'b0;
      rises    <= '0;
      wr_lat   <= 1'b0;
      hi_run   <= '0;
    end else begin
      mdc_prev <= mdc;
      if (cmd_valid && !busy) begin
        rises  <= '0;
        wr_lat <= cmd_write;
      end else if (mdc && !mdc_prev) begin
        rises <= rises + 1'b1;
      end
      if (mdc) hi_run <= hi_run + 1'b1;
      else     hi_run <= '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R11

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && (mdc != mdc_prev)) |-> $stable(mdio_o)); // R4

  AST_OE_STEADY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_prev) |-> $stable(mdio_oe)); // R5

  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> !mdc); // R8

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == (wr_lat ? 8'd64 : 8'd63))); // R4

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc && mdc_prev) |-> (hi_run == 16'(PHASE_CLKS))); // R12

endmodule

bind mdio_frame_master mdio_frame_master_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;

  localparam int D = 2;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_write;
  logic [4:0]  cmd_phy;
  logic [4:0]  cmd_reg;
  logic [15:0] cmd_wdata;
  logic        busy;
  logic        done;
  logic [15:0] rd_data;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mdio_frame_master #(.PHASE_CLKS(D)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] phy_rd, input bit poke);
    logic [63:0] got = '0;
    logic [63:0] al;
    logic [15:0] rdv = '0;
    logic        pm = 1'b0;
    logic        lvl = 1'b0;
    bit          seen = 0;
    int nb = 0, rises = 0, zrises = 0, fc = 0, idx = 1, oe0 = 0, hi = 0;
    int badrun = 0, badstable = 0, exp_idx;
    @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R11 idle before frame", {busy, mdc, mdio_oe}, 0);
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = poke;
    if (poke) begin
      cmd_write = ~wr; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd;
    end
    while (!seen && idx < 5000) begin
      if (mdc && !pm) begin
        rises++;
        if (mdio_oe) begin got = {got[62:0], mdio_o}; nb++; lvl = mdio_o; end
        else zrises++;
      end
      if (mdc && pm && mdio_oe && (mdio_o !== lvl)) badstable++;
      if (mdc) hi++;
      else begin
        if (pm && hi != D) badrun++;
        hi = 0;
      end
      if (!mdc && pm) fc++;
      if (!mdio_oe && !done) oe0++;
      mdio_i = (!wr && fc >= 47 && fc <= 62) ? phy_rd[15 - (fc - 47)] : 1'b1;
      if (done) begin
        seen = 1; rdv = rd_data;
      end else begin
        pm = mdc; idx++;
        @(negedge clk);
      end
    end
    cmd_valid = 1'b0;
    al = got << (64 - nb);
    exp_idx = wr ? (193 * D + 1) : (173 * D + 1);
    chk(seen, "R4 done reached", seen, 1);
    chk(al[63:32] == 32'hFFFF_FFFF, "R1 preamble", al[63:32], 32'hFFFF_FFFF);
    chk(al[31:28] == (wr ? 4'b0101 : 4'b0110), "R2 start and opcode", al[31:28], wr ? 4'b0101 : 4'b0110);
    chk(al[27:18] == {pa, ra}, "R3 addresses", al[27:18], {pa, ra});
    chk(nb == (wr ? 64 : 46), "R4 driven bit count", nb, wr ? 64 : 46);
    chk(idx == exp_idx, "R4 frame length", idx, exp_idx);
    chk(badstable == 0, "R4 data stable while clock high", badstable, 0);
    chk(badrun == 0, "R12 high phase length", badrun, 0);
    if (wr) begin
      chk(al[17:0] == {2'b10, wd}, "R7 turnaround and data", al[17:0], {2'b10, wd});
      chk(zrises == 0, "R8 no clock with line released", zrises, 0);
      chk(oe0 == D, "R8 release phase length", oe0, D);
    end else begin
      chk(zrises == 17, "R5 turnaround plus data pulses undriven", zrises, 17);
      chk(oe0 == 35 * D, "R5 released cycles", oe0, 35 * D);
      chk(rdv == phy_rd, "R6 read data", rdv, phy_rd);
    end
    if (poke) chk(al[27:18] == {pa, ra} && (wr ? al[15:0] == wd : rdv == phy_rd),
                  "R9 command while busy ignored", al[27:18], {pa, ra});
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle and busy drops", {done, busy}, 0);
    mdio_i = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_phy = '0; cmd_reg = '0;
    cmd_wdata = '0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R11 reset state", {busy, done, mdc, mdio_oe}, 0);
    for (int i = 0; i < 32; i++) begin
      run_frame(1'b1, i[4:0], 5'(31 - i), 16'(i * 16'h0811) ^ 16'hA5C3, 16'h0, i == 5);
      run_frame(1'b0, 5'(31 - i), i[4:0], 16'h0, ~16'(i * 16'h1357), i == 9);
    end
    for (int k = 0; k < 16; k++) begin
      run_frame(1'b1, 5'd1, 5'(k), 16'(1 << k), 16'h0, 1'b0);
      run_frame(1'b0, 5'd2, 5'(k), 16'h0, 16'(1 << k), 1'b0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule